// File: doc/BRIEF.md
# Switching Converter Fault Supervisor

This block sequences the gate of a switching power stage and shuts it down when it finds one of two faults. A strobe marks the start of each switching period and raises the gate. A current-limit comparator flag ends the on-pulse early. Each current-sense flag is ignored for its own number of cycles at the start of every on-pulse, and the overshoot flag has the shorter window. Every comparator flag arrives already synchronous to the system clock.

An output short is found when the zero-crossing-low flag stays high for a set number of consecutive clocks. A winding short is found when the overshoot flag, once past its blanking window, fires in four switching periods in a row. When either fault is found, the gate drops at once. A mode input, sampled when the fault is found, picks what follows. In auto-recovery mode the block waits a fixed restart interval and then runs again. In latch mode it stays off until a synchronous reset. All durations are counts of clock cycles set by parameters.

Top module: `pwr_fault_seq`

## Requirements
- R1: While `rst` is high, `status` is 0 (idle) and `gate_en` is 0. On the first clock edge after `rst` falls, `status` becomes 1 (running).
- R2: While running, a clock edge that samples `sw_strobe` high sets `gate_en` to 1. The gate stays high until a qualified limit trip or a fault. A later strobe keeps it high.
- R3: Let k be the number of edges since the edge that raised the gate (k=0 in the first on cycle). `cs_limit` is ignored while k < `LIM_BLANK`. If it is high at k >= `LIM_BLANK`, `gate_en` goes low on that edge and stays low until the next strobe.
- R4: `cs_over` is ignored while k < `OVR_BLANK`. Any number of periods whose only overshoot falls in that window never raises a fault.
- R5: A period counts as tripped when it has at least one unblanked `cs_over` cycle. When the strobe that ends the `N_WIND`-th tripped period in a row is sampled, `gate_en` drops on that edge. `status` then becomes 3 (winding short) in auto mode, or 4 (latched) in latch mode.
- R6: A period with no unblanked overshoot sets the consecutive-period count back to zero.
- R7: If `zcd_low` is sampled high on `T_SHORT` consecutive edges while running, `gate_en` drops on the last of those edges. `status` then becomes 2 (output short) in auto mode, or 4 in latch mode. A single low sample restarts the count.
- R8: In auto mode a fault status lasts exactly `T_RESTART` edges and then returns to 1. Strobes are ignored during that time. On return, `gate_en` stays low until the next strobe.
- R9: `auto_mode` = 1 selects auto-recovery and 0 selects latch-off. Status 4 holds, with `gate_en` low and strobes ignored, until `rst` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, also clears the latched state |
| sw_strobe | input | 1 | One-cycle pulse at the start of each switching period |
| cs_limit | input | 1 | Cycle-by-cycle current limit comparator flag |
| cs_over | input | 1 | Current overshoot (winding short) comparator flag |
| zcd_low | input | 1 | Zero-crossing voltage below short threshold |
| auto_mode | input | 1 | 1 = auto-recovery, 0 = latch-off |
| gate_en | output | 1 | Registered gate enable |
| status | output | 3 | 0 idle, 1 running, 2 output short, 3 winding short, 4 latched |

## Verification
The assertions assume three things about the inputs: `sw_strobe` is a clean single-cycle pulse, every flag is already synchronous to `clk`, and `rst` is high from time zero. So the only way the gate can fall while the block keeps running is a limit trip sampled one edge earlier. The stimulus changes inputs only on falling clock edges and keeps every strobe one cycle wide. It holds each current-sense flag for exactly one cycle at a chosen on-time index, so each blanking boundary is swept cycle by cycle. The zero-crossing flag is held for run lengths one short of, and exactly equal to, the short-detection count.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUN    = 3'd1,
    ST_OSHORT = 3'd2,
    ST_WSHORT = 3'd3,
    ST_LATCH  = 3'd4
  } pfs_state_e;
endpackage

// File: rtl/pfs_blank.sv
// On-time counter shared by both blanking windows; qualifies the sense flags.
module pfs_blank #(
  parameter int unsigned LIM_BLANK = 40,
  parameter int unsigned OVR_BLANK = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic gate,
  input  logic cs_limit,
  input  logic cs_over,
  output logic lim_hit,
  output logic ovr_hit
);
  localparam int unsigned CAP = (LIM_BLANK > OVR_BLANK) ? LIM_BLANK : OVR_BLANK;
  localparam int unsigned CW  = $clog2(CAP + 2);

  logic [CW-1:0] on_cnt;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      on_cnt <= '0;
    end else if (gate && (on_cnt != CW'(CAP))) begin
      on_cnt <= on_cnt + 1'b1;
    end
  end

  assign lim_hit = gate && cs_limit && (on_cnt >= CW'(LIM_BLANK));
  assign ovr_hit = gate && cs_over  && (on_cnt >= CW'(OVR_BLANK));

  // R3
  on_cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    on_cnt <= CW'(CAP));
endmodule

// File: rtl/pfs_short.sv
// Persistence timer for the zero-crossing-low flag.
module pfs_short #(
  parameter int unsigned T_SHORT = 11_250_000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic zlow,
  output logic fault
);
  localparam int unsigned CW = $clog2(T_SHORT + 1);

  logic [CW-1:0] cnt;

  assign fault = en && zlow && (cnt == CW'(T_SHORT - 1));

  always_ff @(posedge clk) begin
    if (rst || !en || !zlow || fault) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7
  short_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(T_SHORT));
  // R7
  short_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !zlow) |=> (cnt == '0));
endmodule

// File: rtl/pfs_wind.sv
// Counts consecutive switching periods that saw a qualified overshoot.
module pfs_wind #(
  parameter int unsigned N_WIND = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic strobe,
  input  logic ovr_hit,
  output logic fault
);
  localparam int unsigned CW = $clog2(N_WIND + 1);

  logic          seen;
  logic [CW-1:0] cnt;
  logic          seen_now;

  assign seen_now = seen || ovr_hit;
  assign fault    = strobe && seen_now && (cnt == CW'(N_WIND - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      seen <= 1'b0;
      cnt  <= '0;
    end else if (strobe) begin
      seen <= 1'b0;
      if (seen_now && !fault) cnt <= cnt + 1'b1;
      else                    cnt <= '0;
    end else if (ovr_hit) begin
      seen <= 1'b1;
    end
  end

  // R5
  wind_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(N_WIND));
  // R6
  wind_clean_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && !seen && !ovr_hit) |=> (cnt == '0));
endmodule

// File: rtl/pwr_fault_seq.sv
module pwr_fault_seq #(
  parameter int unsigned T_SHORT   = 11_250_000,
  parameter int unsigned T_RESTART = 500_000_000,
  parameter int unsigned LIM_BLANK = 40,
  parameter int unsigned OVR_BLANK = 15,
  parameter int unsigned N_WIND    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sw_strobe,
  input  logic       cs_limit,
  input  logic       cs_over,
  input  logic       zcd_low,
  input  logic       auto_mode,
  output logic       gate_en,
  output logic [2:0] status
);
  import pfs_pkg::*;

  localparam int unsigned RW = $clog2(T_RESTART + 1);

  pfs_state_e    state_q;
  logic          gate_q;
  logic [RW-1:0] rcnt;
  logic          run;
  logic          start;
  logic          lim_hit;
  logic          ovr_hit;
  logic          wind_flt;
  logic          short_flt;

  assign run   = (state_q == ST_RUN);
  assign start = run && sw_strobe;

  pfs_blank #(.LIM_BLANK(LIM_BLANK), .OVR_BLANK(OVR_BLANK)) u_blank (
    .clk(clk), .rst(rst), .start(start), .gate(gate_q),
    .cs_limit(cs_limit), .cs_over(cs_over),
    .lim_hit(lim_hit), .ovr_hit(ovr_hit)
  );

  pfs_short #(.T_SHORT(T_SHORT)) u_short (
    .clk(clk), .rst(rst), .en(run), .zlow(zcd_low), .fault(short_flt)
  );

  pfs_wind #(.N_WIND(N_WIND)) u_wind (
    .clk(clk), .rst(rst), .clr(!run), .strobe(start),
    .ovr_hit(ovr_hit), .fault(wind_flt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      gate_q  <= 1'b0;
      rcnt    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          state_q <= ST_RUN;
          gate_q  <= 1'b0;
        end
        ST_RUN: begin
          rcnt <= '0;
          if (wind_flt) begin
            state_q <= auto_mode ? ST_WSHORT : ST_LATCH;
            gate_q  <= 1'b0;
          end else if (short_flt) begin
            state_q <= auto_mode ? ST_OSHORT : ST_LATCH;
            gate_q  <= 1'b0;
          end else if (sw_strobe) begin
            gate_q <= 1'b1;
          end else if (lim_hit) begin
            gate_q <= 1'b0;
          end
        end
        ST_OSHORT, ST_WSHORT: begin
          gate_q <= 1'b0;
          if (rcnt == RW'(T_RESTART - 1)) begin
            state_q <= ST_RUN;
            rcnt    <= '0;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
        default: begin
          state_q <= ST_LATCH;
          gate_q  <= 1'b0;
        end
      endcase
    end
  end

  assign gate_en = gate_q;
  assign status  = state_q;

  // R1
  idle_to_run_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |=> (state_q == ST_RUN));
  // R2
  gate_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_q) |-> $past(sw_strobe));
  // R3
  lim_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && $fell(gate_q)) |-> $past(cs_limit));
  // R8
  restart_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OSHORT || state_q == ST_WSHORT) |-> (rcnt < RW'(T_RESTART)));
  // R8
  resume_low_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(state_q) != ST_RUN) |-> !gate_q);
  // R9
  gate_only_run_chk: assert property (@(posedge clk) disable iff (rst)
    gate_q |-> run);
  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LATCH) |=> (state_q == ST_LATCH));
endmodule

// File: tb/pwr_fault_seq_bench.sv
module pwr_fault_seq_bench;
  localparam int SH = 20;
  localparam int RS = 30;
  localparam int LL = 6;
  localparam int LO = 2;
  localparam int NW = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sw_strobe = 1'b0;
  logic       cs_limit = 1'b0;
  logic       cs_over = 1'b0;
  logic       zcd_low = 1'b0;
  logic       auto_mode = 1'b1;
  logic       gate_en;
  logic [2:0] status;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pwr_fault_seq #(
    .T_SHORT(SH), .T_RESTART(RS), .LIM_BLANK(LL), .OVR_BLANK(LO), .N_WIND(NW)
  ) u_pwr_fault_seq (
    .clk(clk), .rst(rst), .sw_strobe(sw_strobe), .cs_limit(cs_limit),
    .cs_over(cs_over), .zcd_low(zcd_low), .auto_mode(auto_mode),
    .gate_en(gate_en), .status(status)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic strobe();
    sw_strobe = 1'b1;
    tick();
    sw_strobe = 1'b0;
  endtask

  // one 10-cycle period; overshoot for one cycle at on-time index 'at' (<0: none)
  task automatic period(input int at, input string tag);
    strobe();
    chk({tag, " status at strobe"}, status, 1);
    if (at >= 0) begin
      repeat (at) tick();
      cs_over = 1'b1;
      tick();
      cs_over = 1'b0;
      repeat (8 - at) tick();
    end else begin
      repeat (9) tick();
    end
  endtask

  initial begin
    repeat (3) tick();
    chk("R1 status in reset", status, 0);
    chk("R1 gate in reset", gate_en, 0);
    rst = 1'b0;
    tick();
    chk("R1 status after release", status, 1);
    chk("R1 gate after release", gate_en, 0);

    // R2
    strobe();
    chk("R2 gate after strobe", gate_en, 1);
    repeat (10) tick();
    chk("R2 gate holds", gate_en, 1);
    strobe();
    chk("R2 gate held over strobe", gate_en, 1);

    // R3 sweep of limit trip position across the blanking boundary
    for (int k = 0; k <= LL + 3; k++) begin
      strobe();
      repeat (k) tick();
      cs_limit = 1'b1;
      tick();
      cs_limit = 1'b0;
      chk($sformatf("R3 gate after trip at k=%0d", k), gate_en, (k < LL) ? 1 : 0);
    end
    repeat (3) tick();
    chk("R3 gate stays low", gate_en, 0);

    // R4: overshoot only inside its blanking window, many periods
    for (int i = 0; i < NW + 2; i++) period(i % LO, "R4");
    period(-1, "R4");

    // R6 then R5
    repeat (3) period(LO, "R6");
    period(-1, "R6");
    repeat (4) period(LO, "R6");
    strobe();
    chk("R5 status winding short", status, 3);
    chk("R5 gate dropped", gate_en, 0);

    // R8: restart interval, strobe inside it ignored
    for (int i = 1; i < RS; i++) begin
      sw_strobe = (i == 5);
      tick();
    end
    sw_strobe = 1'b0;
    chk("R8 still faulted", status, 3);
    chk("R8 gate low in fault", gate_en, 0);
    tick();
    chk("R8 back to run", status, 1);
    chk("R8 gate low on return", gate_en, 0);
    strobe();
    chk("R8 gate after new strobe", gate_en, 1);

    // R7
    zcd_low = 1'b1;
    repeat (SH - 1) tick();
    zcd_low = 1'b0;
    tick();
    chk("R7 no fault short run", status, 1);
    zcd_low = 1'b1;
    repeat (SH - 1) tick();
    chk("R7 no fault one short", status, 1);
    tick();
    zcd_low = 1'b0;
    chk("R7 output short status", status, 2);
    chk("R7 gate dropped", gate_en, 0);
    repeat (RS) tick();
    chk("R8 return after output short", status, 1);

    // R9 latch on output short
    auto_mode = 1'b0;
    zcd_low = 1'b1;
    repeat (SH) tick();
    zcd_low = 1'b0;
    chk("R9 latched on short", status, 4);
    for (int i = 0; i < RS + 6; i++) begin
      sw_strobe = (i % 3 == 0);
      tick();
    end
    sw_strobe = 1'b0;
    chk("R9 latch holds", status, 4);
    chk("R9 gate low in latch", gate_en, 0);
    rst = 1'b1;
    tick();
    chk("R9 reset clears latch", status, 0);
    rst = 1'b0;
    tick();
    chk("R9 running after reset", status, 1);

    // R9 latch on winding short
    repeat (NW) period(LO, "R9");
    strobe();
    chk("R9 latched on winding", status, 4);
    chk("R9 gate low", gate_en, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule